// File: doc/BRIEF.md
# Configuration Request TLP Packer

The packer takes one configuration read or write request and turns it into a short stream of 64-bit beats for a root-port transmit path. Each beat carries a low word and a high word, plus start-of-packet and end-of-packet flags. The request holds the target bus, the device/function, a 12-bit register offset, the write data, the current root bus number and a read/write select. It enters through a valid/ready handshake. The beats leave through a second valid/ready handshake.

The packet is a three-dword header followed by one data dword. The header type depends on whether the target bus is the root bus. Where the data dword lands, and so how many beats the packet takes, depends on whether the offset is aligned to a quadword. The request is registered when it is accepted. Only one request is in flight at a time.

Top module: `cfg_tlp_packer`

## Requirements
- R1: After reset, req_ready_o is 1 and beat_valid_o is 0. req_ready_o is 1 exactly when no beat is pending.
- R2: Bits 31:24 of header dword 0 hold the format/type code:
  - 0x04 for a read when the target bus equals root_bus_i.
  - 0x05 for a read to any other bus.
  - 0x44 for a write when the target bus equals root_bus_i.
  - 0x45 for a write to any other bus.
- R3: Bits 23:0 of header dword 0 are 0x000001, which sets a length of one dword with all other fields zero.
- R4: Header dword 1 is built as follows:
  - Bits 31:24 hold root_bus_i and bits 23:16 hold the device/function.
  - Bits 15:8 hold the tag: RD_TAG (default 0x3A) for reads, WR_TAG (default 0x5B) for writes.
  - Bits 7:4 are 0 and bits 3:0 are 0xF.
- R5: Header dword 2 is built as follows:
  - Bits 31:24 hold the target bus and bits 23:16 hold the device/function.
  - Bits 11:2 hold offset[11:2].
  - All other bits are 0.
- R6: The first beat carries header dword 0 in beat_lo_o and header dword 1 in beat_hi_o, with start-of-packet set.
- R7: A write whose offset[2:0] is not 0 takes two beats. The second beat has header dword 2 in the low word, the write data in the high word, and end-of-packet set.
- R8: A write whose offset[2:0] is 0 takes three beats:
  - The second beat has header dword 2 in the low word, zero in the high word, and no flags.
  - The third beat has the write data in the low word, zero in the high word, and end-of-packet set.
- R9: A read always takes the two-beat form with a zero data dword, whatever the offset alignment.
- R10: While beat_valid_o is 1 and beat_ready_i is 0, the beat and its flags stay unchanged in the next cycle.
- R11: No request is accepted while a packet is pending. Request inputs that change during a packet do not affect it. req_ready_o rises in the cycle after the end-of-packet beat is taken.
- R12: Start-of-packet is set only on the first beat and end-of-packet only on the last beat. The two are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_devfn_i | input | 8 | Target device/function |
| req_offset_i | input | 12 | Register byte offset |
| req_wdata_i | input | 32 | Write data |
| root_bus_i | input | 8 | Current root bus number |
| beat_valid_o | output | 1 | Beat valid |
| beat_ready_i | input | 1 | Beat taken when high with valid |
| beat_lo_o | output | 32 | Low word of beat |
| beat_hi_o | output | 32 | High word of beat |
| beat_sop_o | output | 1 | Start of packet |
| beat_eop_o | output | 1 | End of packet |

## Verification
Two events can meet in one cycle: the end-of-packet beat being taken, and a request waiting at the input. The bench holds req_valid_i high with scrambled fields for the whole packet, under random back-pressure. It lowers req_valid_i only in the cycle where the last beat is taken, and it presents the next request in the very next cycle. The check passes when req_ready_o stays low through every pending beat, the scrambled fields never show up in the output, and the following packet matches its own request exactly.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int OFF_W   = 12;
  localparam int DW_W    = 32;
  localparam int TAG_W   = 8;

  typedef logic [DW_W-1:0] dword_t;

  localparam logic [7:0] FT_RD_T0 = 8'h04;
  localparam logic [7:0] FT_RD_T1 = 8'h05;
  localparam logic [7:0] FT_WR_T0 = 8'h44;
  localparam logic [7:0] FT_WR_T1 = 8'h45;

  typedef struct packed {
    logic               write;
    logic [BUS_W-1:0]   bus;
    logic [DEVFN_W-1:0] devfn;
    logic [OFF_W-1:0]   offset;
    dword_t             wdata;
    logic [BUS_W-1:0]   root_bus;
  } cfg_req_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_MID  = 2'd2,
    ST_DATA = 2'd3
  } seq_st_e;
endpackage

// File: rtl/cfg_req_reg.sv
module cfg_req_reg
  import cfg_tlp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  cfg_req_t req_i,
  output cfg_req_t req_o
);
  cfg_req_t req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= '0;
    else if (load_i) req_q <= req_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
  import cfg_tlp_pkg::*;
#(
  parameter logic [TAG_W-1:0] RD_TAG = 8'h3A,
  parameter logic [TAG_W-1:0] WR_TAG = 8'h5B
) (
  input  cfg_req_t req_i,
  output dword_t   dw0_o,
  output dword_t   dw1_o,
  output dword_t   dw2_o,
  output dword_t   data_o,
  output logic     aligned_o
);
  localparam int LEN_W = 10;
  localparam int BE_W  = 4;

  logic             local_bus;
  logic [7:0]       fmt_type;
  logic [TAG_W-1:0] tag;

  assign local_bus = (req_i.bus == req_i.root_bus);

  always_comb begin
    unique case ({req_i.write, local_bus})
      2'b00:   fmt_type = FT_RD_T1;
      2'b01:   fmt_type = FT_RD_T0;
      2'b10:   fmt_type = FT_WR_T1;
      default: fmt_type = FT_WR_T0;
    endcase
  end

  assign tag = req_i.write ? WR_TAG : RD_TAG;

  assign dw0_o = {fmt_type, {(DW_W-8-LEN_W){1'b0}}, LEN_W'(1)};
  assign dw1_o = {req_i.root_bus, req_i.devfn, tag, {(DW_W-BUS_W-DEVFN_W-TAG_W-BE_W){1'b0}},
                  {BE_W{1'b1}}};
  assign dw2_o = {req_i.bus, req_i.devfn, {(DW_W-BUS_W-DEVFN_W-OFF_W){1'b0}},
                  req_i.offset[OFF_W-1:2], 2'b00};

  // reads never carry payload
  assign data_o    = req_i.write ? req_i.wdata : '0;
  // quadword-aligned form applies to writes only
  assign aligned_o = req_i.write && (req_i.offset[2:0] == 3'b000);
endmodule

// File: rtl/cfg_beat_seq.sv
module cfg_beat_seq
  import cfg_tlp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   aligned_i,
  input  dword_t dw0_i,
  input  dword_t dw1_i,
  input  dword_t dw2_i,
  input  dword_t data_i,
  output logic   idle_o,
  output logic   beat_valid_o,
  input  logic   beat_ready_i,
  output dword_t beat_lo_o,
  output dword_t beat_hi_o,
  output logic   beat_sop_o,
  output logic   beat_eop_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i)      st_d = ST_HDR;
      ST_HDR:  if (beat_ready_i) st_d = ST_MID;
      ST_MID:  if (beat_ready_i) st_d = aligned_i ? ST_DATA : ST_IDLE;
      default: if (beat_ready_i) st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    beat_lo_o  = '0;
    beat_hi_o  = '0;
    beat_sop_o = 1'b0;
    beat_eop_o = 1'b0;
    unique case (st_q)
      ST_HDR: begin
        beat_lo_o  = dw0_i;
        beat_hi_o  = dw1_i;
        beat_sop_o = 1'b1;
      end
      ST_MID: begin
        beat_lo_o  = dw2_i;
        beat_hi_o  = aligned_i ? '0 : data_i;
        beat_eop_o = !aligned_i;
      end
      ST_DATA: begin
        beat_lo_o  = data_i;
        beat_eop_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign idle_o       = (st_q == ST_IDLE);
  assign beat_valid_o = !idle_o;

  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_lo_o) &&
      $stable(beat_hi_o) && $stable(beat_sop_o) && $stable(beat_eop_o));
  // R11
  ready_after_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && beat_eop_o |=> idle_o);
  // R12
  sop_eop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !(beat_sop_o && beat_eop_o));
  // R6
  first_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> beat_valid_o && beat_sop_o);
endmodule

// File: rtl/cfg_tlp_packer.sv
module cfg_tlp_packer
  import cfg_tlp_pkg::*;
#(
  parameter logic [7:0] RD_TAG = 8'h3A,
  parameter logic [7:0] WR_TAG = 8'h5B
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [7:0]  req_bus_i,
  input  logic [7:0]  req_devfn_i,
  input  logic [11:0] req_offset_i,
  input  logic [31:0] req_wdata_i,
  input  logic [7:0]  root_bus_i,
  output logic        beat_valid_o,
  input  logic        beat_ready_i,
  output logic [31:0] beat_lo_o,
  output logic [31:0] beat_hi_o,
  output logic        beat_sop_o,
  output logic        beat_eop_o
);
  cfg_req_t req_in, req_q;
  dword_t   dw0, dw1, dw2, data;
  logic     aligned, idle, accept;

  assign req_in = '{write: req_write_i, bus: req_bus_i, devfn: req_devfn_i,
                    offset: req_offset_i, wdata: req_wdata_i, root_bus: root_bus_i};
  assign accept      = req_valid_i && idle;
  assign req_ready_o = idle;

  cfg_req_reg u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .req_i  (req_in),
    .req_o  (req_q)
  );

  cfg_hdr_build #(.RD_TAG(RD_TAG), .WR_TAG(WR_TAG)) u_hdr (
    .req_i     (req_q),
    .dw0_o     (dw0),
    .dw1_o     (dw1),
    .dw2_o     (dw2),
    .data_o    (data),
    .aligned_o (aligned)
  );

  cfg_beat_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept),
    .aligned_i    (aligned),
    .dw0_i        (dw0),
    .dw1_i        (dw1),
    .dw2_i        (dw2),
    .data_i       (data),
    .idle_o       (idle),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .beat_lo_o    (beat_lo_o),
    .beat_hi_o    (beat_hi_o),
    .beat_sop_o   (beat_sop_o),
    .beat_eop_o   (beat_eop_o)
  );

  // R3
  hdr_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_sop_o |-> beat_lo_o[23:0] == 24'h000001);
  // R1
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !req_ready_o);
endmodule

// File: tb/cfg_tlp_packer_tb.sv
module cfg_tlp_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam logic [7:0] TB_RD_TAG = 8'h3A;
  localparam logic [7:0] TB_WR_TAG = 8'h5B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_devfn = '0, root_bus = '0;
  logic [11:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, beat_valid, beat_sop, beat_eop;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_lo, beat_hi;

  int n_chk = 0, n_fail = 0;
  logic [65:0] exp_b [3];
  int          exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_tlp_packer u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bus_i(req_bus), .req_devfn_i(req_devfn), .req_offset_i(req_offset),
    .req_wdata_i(req_wdata), .root_bus_i(root_bus),
    .beat_valid_o(beat_valid), .beat_ready_i(beat_ready),
    .beat_lo_o(beat_lo), .beat_hi_o(beat_hi),
    .beat_sop_o(beat_sop), .beat_eop_o(beat_eop)
  );

  task automatic chk(input string r, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // expected beats as {sop, eop, lo, hi}
  task automatic build_exp(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                           input logic [11:0] off, input logic [31:0] wd, input logic [7:0] rb);
    logic [7:0]  ft;
    logic [31:0] d0, d1, d2, dat;
    if (wr) ft = (bus == rb) ? 8'h44 : 8'h45;
    else    ft = (bus == rb) ? 8'h04 : 8'h05;
    d0  = {ft, 24'h000001};
    d1  = {rb, devfn, wr ? TB_WR_TAG : TB_RD_TAG, 8'h0F};
    d2  = {bus, devfn, 4'h0, off[11:2], 2'b00};
    dat = wr ? wd : 32'h0;
    exp_b[0] = {2'b10, d0, d1};
    if (wr && off[2:0] == 3'd0) begin
      exp_n    = 3;
      exp_b[1] = {2'b00, d2, 32'h0};
      exp_b[2] = {2'b01, dat, 32'h0};
    end else begin
      exp_n    = 2;
      exp_b[1] = {2'b01, d2, dat};
      exp_b[2] = '0;
    end
  endtask

  task automatic do_req(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [11:0] off, input logic [31:0] wd, input logic [7:0] rb,
                        input int stall_pct);
    logic [65:0] got [4];
    logic [65:0] prev;
    int          n = 0;
    int          guard = 0;
    logic        stalled = 1'b0;
    logic        rdy;
    string       kind;
    build_exp(wr, bus, devfn, off, wd, rb);
    kind = !wr ? "R9" : (off[2:0] == 3'd0 ? "R8" : "R7");
    req_write = wr; req_bus = bus; req_devfn = devfn;
    req_offset = off; req_wdata = wd; root_bus = rb; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    // scramble held inputs while the packet is pending
    req_write = $urandom; req_bus = $urandom; req_devfn = $urandom;
    req_offset = $urandom; req_wdata = $urandom; root_bus = $urandom;
    while (1) begin
      guard++;
      if (guard > 200) begin
        chk("R11 packet stuck", 68'd0, 68'd1);
        break;
      end
      if (beat_valid) begin
        chk("R11 ready low while busy", {67'd0, req_ready}, 68'd0);
        if (stalled) chk("R10 hold", {2'b0, beat_sop, beat_eop, beat_lo, beat_hi}, {2'b0, prev});
        rdy = ($urandom % 100) >= stall_pct;
        beat_ready = rdy;
        prev = {beat_sop, beat_eop, beat_lo, beat_hi};
        stalled = !rdy;
        if (rdy) begin
          if (n < 4) got[n] = prev;
          n++;
          if (beat_eop || n >= 4) req_valid = 1'b0;
        end
        @(negedge clk);
        beat_ready = 1'b0;
        if (rdy && (prev[64] || n >= 4)) break;
      end else begin
        chk("R11 beat valid after accept", 68'd0, 68'd1);
        @(negedge clk);
      end
    end
    chk({kind, " beat count"}, 68'(n), 68'(exp_n));
    chk("R11 ready after eop", {67'd0, req_ready}, 68'd1);
    if (n >= 1) begin
      chk("R2 fmt/type", 68'(got[0][63:56]), 68'(exp_b[0][63:56]));
      chk("R3 dw0 rest", 68'(got[0][55:32]), 68'(exp_b[0][55:32]));
      chk("R4 dw1", 68'(got[0][31:0]), 68'(exp_b[0][31:0]));
      chk("R6 first flags", 68'(got[0][65:64]), 68'(2'b10));
    end
    for (int i = 1; i < exp_n && i < n; i++) begin
      chk(i == 1 ? "R5 dw2" : {kind, " data low"}, 68'(got[i][63:32]), 68'(exp_b[i][63:32]));
      chk({kind, " high word"}, 68'(got[i][31:0]), 68'(exp_b[i][31:0]));
      chk("R12 flags", 68'(got[i][65:64]), 68'(exp_b[i][65:64]));
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", {67'd0, req_ready}, 68'd1);
    chk("R1 reset valid", {67'd0, beat_valid}, 68'd0);
    void'($urandom(32'd20240607));
    // directed corners
    do_req(1'b1, 8'h00, 8'h08, 12'h010, 32'hDEADBEEF, 8'h00, 0);  // aligned write, type 0
    do_req(1'b1, 8'h00, 8'h08, 12'h01C, 32'hCAFEF00D, 8'h00, 0);  // unaligned write
    do_req(1'b0, 8'h03, 8'h10, 12'h008, 32'h12345678, 8'h00, 0);  // aligned read, type 1
    do_req(1'b0, 8'h05, 8'hFF, 12'hFFC, 32'hFFFFFFFF, 8'h05, 50); // root bus nonzero
    do_req(1'b1, 8'h07, 8'h01, 12'hFF8, 32'h00000001, 8'h02, 70); // type 1 aligned write
    do_req(1'b1, 8'h02, 8'h00, 12'h004, 32'hA5A5A5A5, 8'h02, 70);
    for (int k = 0; k < 60; k++) begin
      logic [7:0] rb;
      logic [7:0] bus;
      rb  = 8'($urandom % 4);
      bus = ($urandom % 2) ? rb : 8'($urandom);
      do_req(1'($urandom), bus, 8'($urandom), 12'($urandom), $urandom, rb, 40);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        chk("watchdog expired", 68'd0, 68'd1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule